// File: doc/BRIEF.md
# Blanking-Interval Audio Embedder

This block sits in front of a video link serializer whose word carries 18 RGB bits and 9 control bits per pixel clock. Control bit 0 and bit 1 hold the two sync signals and control bit 2 is the RGB data enable: high during active video, low during blanking. The block takes stereo PCM samples from an upstream FIFO-style valid/ready interface. It sends them as a serial audio stream in I2S format on spare control bits, and only inside blanking words. The video content itself is never changed.

Two transfer modes exist. In pixel-clock mode each pixel clock is one bit slot, and an active-low select on control bit 6 tells the far end which words hold a valid bit. In divided-clock mode the block toggles its own bit clock on control bit 5, with programmable high and low phases. It parks that clock low whenever it must pause. A programmable per-interval slot limit caps how much of each blanking interval is used. A sample cut off by active video resumes at the same bit in the next blanking interval. The mode, the half period and the slot limit are expected to stay constant between resets.

Top module: `blank_audio_embed`

## Requirements
- R1: During reset, rgb_o is 0 and smp_ready_o is 1. ctl_o is 9'h040 in pixel-clock mode (select high) and 9'h000 in divided-clock mode.
- R2: Every output word equals the input word from one clock earlier in the RGB bits, control bits 0 to 2, and control bits 7 and 8. Control bit 5 is also unchanged in pixel-clock mode, and control bit 6 in divided-clock mode.
- R3: When the input word had control bit 2 high (active video), the whole output word one clock later equals it, all 27 bits.
- R4: In pixel-clock mode (div_mode_i=0), a blanking output word with control bit 6 low carries exactly one bit slot: serial data on control bit 3 and word select on control bit 4. Control bit 6 is high in every other blanking word.
- R5: In divided-clock mode (div_mode_i=1), a bit slot is a rising edge of control bit 5 between two consecutive blanking words, and control bits 3 and 4 do not change across that edge or while the clock stays high. The clock is high for exactly bclk_half_i+1 words and low for at least bclk_half_i+1 blanking words before each rise.
- R6: No blanking interval carries more bit slots than slot_limit_i. With a limit of 0 no slot is ever sent.
- R7: Each sample occupies 32 consecutive slots: the left word MSB first in slots 0 to 15, then the right word MSB first in slots 16 to 31. Word select is 1 in slots 15 to 30 and 0 in slots 31 and 0 to 14, so it changes one slot before each MSB.
- R8: A sample interrupted by active video or by the slot limit continues at the next untransmitted bit in a later interval, with no bit lost or repeated.
- R9: A sample is accepted at a clock edge where smp_valid_i and smp_ready_o are both high. smp_ready_o is high only while no sample is held. No slot is sent without an accepted sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_mode_i | input | 1 | 0: pixel-clock mode with select, 1: divided-clock mode |
| bclk_half_i | input | DIV_W (4) | Bit clock half period minus one, in pixel clocks |
| slot_limit_i | input | UTIL_W (12) | Maximum bit slots per blanking interval |
| smp_valid_i | input | 1 | Upstream sample available |
| smp_left_i | input | SMP_W (16) | Left channel sample |
| smp_right_i | input | SMP_W (16) | Right channel sample |
| smp_ready_o | output | 1 | Block can accept a sample |
| rgb_i | input | 18 | RGB bits of the incoming link word |
| ctl_i | input | 9 | Control bits of the incoming link word |
| rgb_o | output | 18 | RGB bits to the serializer |
| ctl_o | output | 9 | Control bits to the serializer, with audio inserted |

## Verification
The bench decodes the output the way a far-end receiver would. It rebuilds each stream position from the select-low words or the clock rises, and compares data and word select against the queue of accepted samples. An embedder that lost or repeated a bit when video cut into a sample would shift every later word. An embedder that moved word select onto the MSB would show the wrong value in slots 15 and 31. Short blanking runs, a slot limit of 0 or 5, and a starved input are used to catch a slot leaking past the budget, into active video, or out of an empty holder. In divided-clock mode, a bit clock that rose in the same word its data changed, or had high and low phases of the wrong length, shows up at the edges the bench watches.

// File: rtl/bae_pkg.sv
package bae_pkg;
  localparam int RGB_W = 18;
  localparam int CTL_W = 9;
  localparam int C_VEN = 2;
  localparam int C_SD  = 3;
  localparam int C_WS  = 4;
  localparam int C_BCK = 5;
  localparam int C_SEL = 6;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SEND_BIT = 2'd1,
    ST_HOLD     = 2'd2
  } bae_state_e;
endpackage

// File: rtl/bae_sample_seq.sv
module bae_sample_seq
  import bae_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*SMP_W-1:0] word_i,
  input  logic               adv_i,
  input  logic               active_i,
  output bae_state_e         state_o,
  output logic               bit_o,
  output logic               ws_o
);
  localparam int FRAME = 2 * SMP_W;
  localparam int IDX_W = $clog2(FRAME);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME - 1);
  localparam logic [IDX_W-1:0] WS_FIRST = IDX_W'(SMP_W - 1);

  bae_state_e       state_q;
  logic [FRAME-1:0] sh_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      state_q <= ST_SEND_BIT;
      sh_q    <= word_i;
      idx_q   <= '0;
    end else if (adv_i) begin
      if (idx_q == LAST_IDX) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
      end else begin
        state_q <= active_i ? ST_SEND_BIT : ST_HOLD;
        idx_q   <= idx_q + 1'b1;
      end
      sh_q <= {sh_q[FRAME-2:0], 1'b0};
    end else if (state_q != ST_IDLE) begin
      state_q <= active_i ? ST_SEND_BIT : ST_HOLD;
    end
  end

  assign state_o = state_q;
  assign bit_o   = sh_q[FRAME-1];
  // select leads the channel by one slot
  assign ws_o    = (idx_q >= WS_FIRST) && (idx_q != LAST_IDX);
endmodule

// File: rtl/bae_budget.sv
module bae_budget #(
  parameter int UTIL_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              blank_i,
  input  logic              take_i,
  input  logic [UTIL_W-1:0] limit_i,
  output logic              avail_o
);
  logic [UTIL_W-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      used_q <= '0;
    else if (!blank_i) used_q <= '0;
    else if (take_i)  used_q <= used_q + 1'b1;
  end

  assign avail_o = used_q < limit_i;
endmodule

// File: rtl/bae_bitclk.sv
module bae_bitclk #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             blank_i,
  input  logic             loaded_i,
  input  logic             avail_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int PH_W = DIV_W + 1;

  logic            sck_q, sck_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PH_W-1:0] hi_end, lo_end;

  assign hi_end = PH_W'(half_i);
  assign lo_end = PH_W'(half_i) + PH_W'(1);

  always_comb begin
    sck_d  = sck_q;
    ph_d   = ph_q;
    rise_o = 1'b0;
    fall_o = 1'b0;
    if (!en_i) begin
      sck_d = 1'b0;
      ph_d  = '0;
    end else if (!blank_i) begin
      // video cuts the high phase short; the bit counts as taken
      fall_o = sck_q;
      sck_d  = 1'b0;
      ph_d   = '0;
    end else if (sck_q) begin
      if (ph_q == hi_end) begin
        fall_o = 1'b1;
        sck_d  = 1'b0;
        ph_d   = PH_W'(1);
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end else if (loaded_i) begin
      if (ph_q == lo_end && avail_i) begin
        rise_o = 1'b1;
        sck_d  = 1'b1;
        ph_d   = '0;
      end else if (ph_q != lo_end) begin
        ph_d = ph_q + 1'b1;
      end
    end else begin
      ph_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      ph_q  <= '0;
    end else begin
      sck_q <= sck_d;
      ph_q  <= ph_d;
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/blank_audio_embed.sv
module blank_audio_embed
  import bae_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int DIV_W  = 4,
  parameter int UTIL_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_mode_i,
  input  logic [DIV_W-1:0]  bclk_half_i,
  input  logic [UTIL_W-1:0] slot_limit_i,
  input  logic              smp_valid_i,
  input  logic [SMP_W-1:0]  smp_left_i,
  input  logic [SMP_W-1:0]  smp_right_i,
  output logic              smp_ready_o,
  input  logic [RGB_W-1:0]  rgb_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [RGB_W-1:0]  rgb_o,
  output logic [CTL_W-1:0]  ctl_o
);
  logic       blank, loaded, avail, load;
  logic       pix_fire, take, adv;
  logic       sck, rise, fall;
  logic       cur_bit, cur_ws;
  bae_state_e state;

  logic             sd_q, ws_q, sel_n_q;
  logic [RGB_W-1:0] rgb_q;
  logic [CTL_W-1:0] ctl_q;

  assign blank       = !ctl_i[C_VEN];
  assign loaded      = state != ST_IDLE;
  assign smp_ready_o = !loaded;
  assign load        = smp_valid_i && !loaded;
  assign pix_fire    = !div_mode_i && loaded && blank && avail;
  assign take        = div_mode_i ? rise : pix_fire;
  assign adv         = div_mode_i ? fall : pix_fire;

  bae_sample_seq #(.SMP_W(SMP_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .word_i   ({smp_left_i, smp_right_i}),
    .adv_i    (adv),
    .active_i (blank && avail),
    .state_o  (state),
    .bit_o    (cur_bit),
    .ws_o     (cur_ws)
  );

  bae_budget #(.UTIL_W(UTIL_W)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .blank_i (blank),
    .take_i  (take),
    .limit_i (slot_limit_i),
    .avail_o (avail)
  );

  bae_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (div_mode_i),
    .blank_i  (blank),
    .loaded_i (loaded),
    .avail_i  (avail),
    .half_i   (bclk_half_i),
    .sck_o    (sck),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgb_q   <= '0;
      ctl_q   <= '0;
      sd_q    <= 1'b0;
      ws_q    <= 1'b0;
      sel_n_q <= 1'b1;
    end else begin
      rgb_q <= rgb_i;
      ctl_q <= ctl_i;
      if (pix_fire) begin
        sd_q    <= cur_bit;
        ws_q    <= cur_ws;
        sel_n_q <= 1'b0;
      end else begin
        sel_n_q <= 1'b1;
      end
    end
  end

  // divided mode shows the held bit straight from registered state
  always_comb begin
    ctl_o = ctl_q;
    if (!ctl_q[C_VEN]) begin
      if (div_mode_i) begin
        ctl_o[C_SD]  = loaded && cur_bit;
        ctl_o[C_WS]  = loaded && cur_ws;
        ctl_o[C_BCK] = sck;
      end else begin
        ctl_o[C_SD]  = sd_q;
        ctl_o[C_WS]  = ws_q;
        ctl_o[C_SEL] = sel_n_q;
      end
    end
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/blank_audio_embed_chk.sv
module blank_audio_embed_chk
  import bae_pkg::*;
#(
  parameter int SMP_W  = 16,
  parameter int DIV_W  = 4,
  parameter int UTIL_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              div_mode_i,
  input logic [DIV_W-1:0]  bclk_half_i,
  input logic [UTIL_W-1:0] slot_limit_i,
  input logic              smp_valid_i,
  input logic [SMP_W-1:0]  smp_left_i,
  input logic [SMP_W-1:0]  smp_right_i,
  input logic              smp_ready_o,
  input logic [RGB_W-1:0]  rgb_i,
  input logic [CTL_W-1:0]  ctl_i,
  input logic [RGB_W-1:0]  rgb_o,
  input logic [CTL_W-1:0]  ctl_o
);
  logic [CTL_W-1:0]  prev_ctl;
  logic              prev_ok;
  logic [UTIL_W:0]   cnt_q;
  logic              slot_now, div_rise;

  assign div_rise = ctl_o[C_BCK] && !(prev_ok && !prev_ctl[C_VEN] && prev_ctl[C_BCK]);
  assign slot_now = !ctl_o[C_VEN] && (div_mode_i ? div_rise : !ctl_o[C_SEL]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ctl <= '0;
      prev_ok  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      prev_ctl <= ctl_o;
      prev_ok  <= 1'b1;
      if (ctl_o[C_VEN]) cnt_q <= '0;
      else if (slot_now) cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_VIDEO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[C_VEN] |=> (ctl_o == $past(ctl_i) && rgb_o == $past(rgb_i))); // R3
  AST_SYNC_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ctl_o[2:0] == $past(ctl_i[2:0]) && ctl_o[8:7] == $past(ctl_i[8:7])
              && rgb_o == $past(rgb_i))); // R2
  AST_SLOT_BUDGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_now |-> ({1'b0, slot_limit_i} > cnt_q)); // R6
  AST_EDGE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_mode_i && prev_ok && !ctl_o[C_VEN] && ctl_o[C_BCK] && !prev_ctl[C_BCK])
    |-> (!prev_ctl[C_VEN] && prev_ctl[C_WS:C_SD] == ctl_o[C_WS:C_SD])); // R5
  AST_ONE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && smp_ready_o) |=> !smp_ready_o); // R9
endmodule

bind blank_audio_embed blank_audio_embed_chk #(
  .SMP_W(SMP_W), .DIV_W(DIV_W), .UTIL_W(UTIL_W)
) u_chk (.*);

// File: tb/blank_audio_embed_bench.sv
module blank_audio_embed_bench;
  localparam int SMP_W = 16;
  localparam int DIV_W = 4;
  localparam int UTIL_W = 12;
  localparam int FR = 2 * SMP_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              div_mode = 1'b0;
  logic [DIV_W-1:0]  half = '0;
  logic [UTIL_W-1:0] lim = '0;
  logic              smp_valid = 1'b0;
  logic [SMP_W-1:0]  smp_l = '0, smp_r = '0;
  logic              smp_ready;
  logic [17:0]       rgb_in = '0, rgb_out;
  logic [8:0]        ctl_in = '0, ctl_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  blank_audio_embed #(.SMP_W(SMP_W), .DIV_W(DIV_W), .UTIL_W(UTIL_W)) u_blank_audio_embed (
    .clk_i(clk), .rst_ni(rst_n), .div_mode_i(div_mode), .bclk_half_i(half),
    .slot_limit_i(lim), .smp_valid_i(smp_valid), .smp_left_i(smp_l), .smp_right_i(smp_r),
    .smp_ready_o(smp_ready), .rgb_i(rgb_in), .ctl_i(ctl_in), .rgb_o(rgb_out), .ctl_o(ctl_out)
  );

  logic [FR-1:0] exp_q[$];
  logic [17:0]   prev_rgb;
  logic [8:0]    prev_ctl;
  bit            pend_v, just_pushed, vid_act, o_prev_blank, o_prev_c5;
  logic [1:0]    o_prev_c43;
  int            vid_rem, slot, ivl_cnt, low_run, high_run, n_slots;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  function automatic bit ws_of(input int s);
    return (s >= SMP_W - 1) && (s <= FR - 2);
  endfunction

  task automatic drive(input int vpct);
    if (vid_rem == 0) begin
      vid_act = !vid_act;
      vid_rem = vid_act ? 10 + int'($urandom % 50) : 8 + int'($urandom % 40);
    end
    vid_rem--;
    rgb_in = 18'($urandom);
    ctl_in = 9'($urandom);
    ctl_in[2] = vid_act;
    if (!pend_v && int'($urandom % 100) < vpct) begin
      pend_v = 1;
      smp_l = 16'($urandom);
      smp_r = 16'($urandom);
    end
    smp_valid = pend_v;
    just_pushed = 0;
    if (pend_v && smp_ready) begin
      exp_q.push_back({smp_l, smp_r});
      pend_v = 0;
      just_pushed = 1;
    end
    prev_rgb = rgb_in;
    prev_ctl = ctl_in;
  endtask

  task automatic observe();
    bit is_slot = 0;
    bit blank_o = !ctl_out[2];
    if (just_pushed) chk(!smp_ready, "R9 ready after accept", 32'(smp_ready), 0);
    if (prev_ctl[2])
      chk(ctl_out == prev_ctl && rgb_out == prev_rgb, "R3 video word", {5'd0, ctl_out, rgb_out}, {5'd0, prev_ctl, prev_rgb});
    else
      chk(rgb_out == prev_rgb && ctl_out[2:0] == prev_ctl[2:0] && ctl_out[8:7] == prev_ctl[8:7]
          && (div_mode ? ctl_out[6] == prev_ctl[6] : ctl_out[5] == prev_ctl[5]),
          "R2 passthrough", {5'd0, ctl_out, rgb_out}, {5'd0, prev_ctl, prev_rgb});
    if (!blank_o) begin
      ivl_cnt = 0; low_run = 0; high_run = 0;
    end else if (!div_mode) begin
      is_slot = !ctl_out[6];
    end else if (ctl_out[5] && !(o_prev_blank && o_prev_c5)) begin
      is_slot = 1;
      chk(o_prev_blank && o_prev_c43 == ctl_out[4:3] && low_run >= int'(half) + 1,
          "R5 rise setup", 32'(low_run), 32'(int'(half) + 1));
      high_run = 1;
    end else if (ctl_out[5]) begin
      high_run++;
      chk(ctl_out[4:3] == o_prev_c43, "R5 hold while high", 32'(ctl_out[4:3]), 32'(o_prev_c43));
    end else begin
      if (high_run > 0) chk(high_run == int'(half) + 1, "R5 high width", 32'(high_run), 32'(int'(half) + 1));
      high_run = 0;
      low_run = (o_prev_blank && !o_prev_c5) ? low_run + 1 : 1;
    end
    o_prev_blank = blank_o;
    o_prev_c5 = ctl_out[5];
    o_prev_c43 = ctl_out[4:3];
    if (is_slot) begin
      n_slots++;
      ivl_cnt++;
      chk(ivl_cnt <= int'(lim), "R6 slot budget", 32'(ivl_cnt), 32'(lim));
      if (exp_q.size() == 0) begin
        chk(0, "R9 slot without sample", 1, 0);
      end else begin
        logic [FR-1:0] cur = exp_q[0];
        logic [1:0] want = {ws_of(slot), cur[FR-1-slot]};
        chk(ctl_out[4:3] == want, (ivl_cnt == 1 && slot != 0) ? "R8 resumed slot" : "R7 slot bits",
            {16'(slot), 14'd0, ctl_out[4:3]}, {16'(slot), 14'd0, want});
        slot++;
        if (slot == FR) begin
          slot = 0;
          void'(exp_q.pop_front());
        end
      end
    end
  endtask

  task automatic run_phase(input bit mode, input int h, input int l, input int vpct, input int ncyc);
    rst_n = 0;
    div_mode = mode;
    half = DIV_W'(h);
    lim = UTIL_W'(l);
    smp_valid = 0;
    rgb_in = '0;
    ctl_in = '0;
    exp_q.delete();
    pend_v = 0; just_pushed = 0; vid_act = 1; vid_rem = 0;
    slot = 0; ivl_cnt = 0; low_run = 0; high_run = 0; n_slots = 0;
    o_prev_blank = 0; o_prev_c5 = 0; o_prev_c43 = '0;
    repeat (3) @(negedge clk);
    chk(rgb_out == '0 && ctl_out == (mode ? 9'h000 : 9'h040) && smp_ready,
        "R1 reset state", {13'd0, smp_ready, ctl_out, rgb_out}, {13'd1, (mode ? 9'h000 : 9'h040), 18'd0});
    rst_n = 1;
    drive(vpct);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      observe();
      drive(vpct);
    end
    if (l == 0) chk(n_slots == 0, "R6 zero limit", 32'(n_slots), 0);
    else if (!mode) chk(n_slots > 20, "R4 pixel mode progress", 32'(n_slots), 21);
    else chk(n_slots > 20, "R5 divided mode progress", 32'(n_slots), 21);
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_phase(0, 0, 4095, 70, 2500);
    run_phase(0, 0, 5, 90, 2500);
    run_phase(0, 0, 0, 90, 800);
    run_phase(0, 0, 4095, 8, 2500);
    run_phase(1, 0, 4095, 80, 2500);
    run_phase(1, 3, 7, 90, 3000);
    run_phase(1, 2, 4095, 10, 3000);
    run_phase(1, 1, 0, 90, 800);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R4 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule